// File: doc/BRIEF.md
# Record Source Selector with Copy Control

This block decides where each stereo frame of the record stream comes from. Two sample streams arrive one sample per strobe, each tagged left or right. One comes from a digital audio receiver and carries its lock state, its copy-generation status and a rate code. The other comes from the local ADC. The host's requested record format (mono or stereo, 16-bit or 8-bit, rate code) is applied to the chosen stream. The result is one frame per output strobe, with a flag that shows which source was used and an error flag.

The receiver stream is used only when all of these hold: the receiver is locked, the data is marked original, its rate is supported, and the request can be met from it. The request can be met from it when the rate matches and at most one of the two reductions is asked for. A locked, original stream that cannot meet the request makes the block fall back to the ADC and raise the error flag. The source is chosen once per frame, when the left sample is taken, so a frame never mixes samples from both sources.

Top module: `rec_src_sel`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame completes, `rec_vld`, `rec_l`, `rec_r`, `rec_from_sp` and `rec_err` are all 0.
- R2: A frame is taken from the receiver stream (`rec_from_sp`=1, `rec_err`=0) when, at its left sample, all of these hold: `sp_lock`=1, `sp_orig`=1, `sp_rate` is 0, 1 or 2, `req_rate` equals `sp_rate`, and mono and 8-bit are not both requested.
- R3: With `sp_lock`=0, frames come from the ADC stream with `rec_err`=0.
- R4: With `sp_orig`=0 (first generation or later), frames come from the ADC stream with `rec_err`=0.
- R5: Rate code `sp_rate`=3 marks an unsupported receiver format. Frames then come from the ADC stream with `rec_err`=0.
- R6: In two cases, a locked, original receiver stream with a supported rate still gives ADC frames, and those frames carry `rec_err`=1. The first case is a `req_rate` that differs from `sp_rate`. The second is a request for both mono and 8-bit.
- R7: With `req_mono`=1, `rec_l` is floor((L+R)/2) of the two signed samples, and `rec_r` is 0.
- R8: With `req_8b`=1, bits [7:0] of each output word carry bits [15:8] of the stereo or mono value, and bits [15:8] are 0. This holds for both sources.
- R9: A frame is a left sample (`*_ch`=0) followed by a right sample (`*_ch`=1). The output frame is presented with a one-cycle `rec_vld` pulse in the cycle after the right sample. A right sample with no pending left is ignored. A repeated left replaces the pending one. Outputs hold between pulses.
- R10: The source is fixed at the left sample. Changes to lock, copy status or request match before the right sample do not move that frame to the other source.
- R11: Loss of `sp_lock` while a receiver frame is pending discards the partial frame. No output is produced, and later frames follow the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_vld | input | 1 | Receiver sample strobe |
| sp_ch | input | 1 | Receiver sample channel, 0 left, 1 right |
| sp_dat | input | 16 | Receiver sample, two's complement |
| sp_lock | input | 1 | Receiver locked on valid data |
| sp_orig | input | 1 | Copy status: 1 original, 0 copied |
| sp_rate | input | 2 | Receiver rate code, 0..2 supported, 3 unsupported |
| adc_vld | input | 1 | ADC sample strobe |
| adc_ch | input | 1 | ADC sample channel, 0 left, 1 right |
| adc_dat | input | 16 | ADC sample, two's complement |
| req_mono | input | 1 | Requested mono record |
| req_8b | input | 1 | Requested 8-bit record |
| req_rate | input | 2 | Requested rate code |
| rec_vld | output | 1 | Output frame strobe |
| rec_l | output | 16 | Output left (or mono) word |
| rec_r | output | 16 | Output right word, 0 in mono |
| rec_from_sp | output | 1 | Frame came from the receiver |
| rec_err | output | 1 | Request could not be met from the receiver |

## Verification
The bench goes after frames whose conditions change between the left and the right sample. A design that re-chose the source per sample would emit frames whose left comes from one stream and whose right comes from the other. If lock drops halfway through a receiver frame, a design that failed to drop the frame would emit a half-trusted frame. The doubly reduced request would be accepted from the receiver if the reduction check were missing. Mono averaging of an odd negative sum is exercised too, where truncation toward zero instead of flooring would be off by one. Stray right samples and repeated lefts are also sent, which a careless pairing would turn into spurious or stale frames.

// File: rtl/rec_src_sel.sv
module rec_src_sel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sp_vld,
  input  logic         sp_ch,
  input  logic [W-1:0] sp_dat,
  input  logic         sp_lock,
  input  logic         sp_orig,
  input  logic [1:0]   sp_rate,
  input  logic         adc_vld,
  input  logic         adc_ch,
  input  logic [W-1:0] adc_dat,
  input  logic         req_mono,
  input  logic         req_8b,
  input  logic [1:0]   req_rate,
  output logic         rec_vld,
  output logic [W-1:0] rec_l,
  output logic [W-1:0] rec_r,
  output logic         rec_from_sp,
  output logic         rec_err
);
  localparam int H = W / 2;
  localparam logic [1:0] RATE_BAD = 2'd3;

  logic         mid, sel, ferr;
  logic [W-1:0] hold;

  logic sp_live, fmt_ok, pick, abort;
  logic in_vld, in_ch;
  logic [W-1:0] in_dat;

  assign sp_live = sp_lock & sp_orig & (sp_rate != RATE_BAD);
  assign fmt_ok  = (req_rate == sp_rate) & ~(req_mono & req_8b);
  assign pick    = mid ? sel : (sp_live & fmt_ok);
  assign abort   = mid & sel & ~sp_lock;

  assign in_vld = pick ? sp_vld : adc_vld;
  assign in_ch  = pick ? sp_ch  : adc_ch;
  assign in_dat = pick ? sp_dat : adc_dat;

  logic signed [W:0] sum;
  logic [W-1:0] a_w, b_w, a_f, b_f;

  assign sum = $signed({hold[W-1], hold}) + $signed({in_dat[W-1], in_dat});
  assign a_w = req_mono ? sum[W:1] : hold;
  assign b_w = req_mono ? '0 : in_dat;
  assign a_f = req_8b ? {{H{1'b0}}, a_w[W-1:H]} : a_w;
  assign b_f = req_8b ? {{H{1'b0}}, b_w[W-1:H]} : b_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid         <= 1'b0;
      sel         <= 1'b0;
      ferr        <= 1'b0;
      hold        <= '0;
      rec_vld     <= 1'b0;
      rec_l       <= '0;
      rec_r       <= '0;
      rec_from_sp <= 1'b0;
      rec_err     <= 1'b0;
    end else begin
      rec_vld <= 1'b0;
      if (abort) begin
        mid <= 1'b0;
      end else if (in_vld && !in_ch) begin
        hold <= in_dat;
        mid  <= 1'b1;
        if (!mid) begin
          sel  <= sp_live & fmt_ok;
          ferr <= sp_live & ~fmt_ok;
        end
      end else if (in_vld && in_ch && mid) begin
        mid         <= 1'b0;
        rec_vld     <= 1'b1;
        rec_l       <= a_f;
        rec_r       <= b_f;
        rec_from_sp <= sel;
        rec_err     <= ferr;
      end
    end
  end
endmodule

module rec_src_sel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sp_vld,
  input logic         sp_ch,
  input logic         sp_lock,
  input logic         adc_vld,
  input logic         adc_ch,
  input logic         req_mono,
  input logic         req_8b,
  input logic         rec_vld,
  input logic [W-1:0] rec_l,
  input logic [W-1:0] rec_r,
  input logic         rec_from_sp,
  input logic         rec_err
);
  localparam int H = W / 2;

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |=> !rec_vld);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_vld |-> $stable({rec_l, rec_r, rec_from_sp, rec_err}));
  // R6
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && rec_err |-> !rec_from_sp);
  // R7
  mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && $past(req_mono) |-> rec_r == '0);
  // R8
  byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && $past(req_8b) |-> (rec_l[W-1:H] == '0) && (rec_r[W-1:H] == '0));
  // R10
  sp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && rec_from_sp |-> $past(sp_vld && sp_ch));
  // R10
  adc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && !rec_from_sp |-> $past(adc_vld && adc_ch));
  // R11
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld && rec_from_sp |-> $past(sp_lock));
endmodule

bind rec_src_sel rec_src_sel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_vld(sp_vld), .sp_ch(sp_ch), .sp_lock(sp_lock),
  .adc_vld(adc_vld), .adc_ch(adc_ch), .req_mono(req_mono), .req_8b(req_8b),
  .rec_vld(rec_vld), .rec_l(rec_l), .rec_r(rec_r),
  .rec_from_sp(rec_from_sp), .rec_err(rec_err)
);

// File: tb/tb_rec_src_sel.sv
`timescale 1ns/1ps
module tb_rec_src_sel;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic sp_vld, sp_ch, sp_lock, sp_orig;
  logic [15:0] sp_dat, adc_dat;
  logic [1:0] sp_rate, req_rate;
  logic adc_vld, adc_ch, req_mono, req_8b;
  logic rec_vld, rec_from_sp, rec_err;
  logic [15:0] rec_l, rec_r;

  rec_src_sel dut (
    .clk(clk), .rst_n(rst_n), .sp_vld(sp_vld), .sp_ch(sp_ch), .sp_dat(sp_dat),
    .sp_lock(sp_lock), .sp_orig(sp_orig), .sp_rate(sp_rate),
    .adc_vld(adc_vld), .adc_ch(adc_ch), .adc_dat(adc_dat),
    .req_mono(req_mono), .req_8b(req_8b), .req_rate(req_rate),
    .rec_vld(rec_vld), .rec_l(rec_l), .rec_r(rec_r),
    .rec_from_sp(rec_from_sp), .rec_err(rec_err)
  );

  int n_chk = 0, n_fail = 0, nfr = 0;
  string cur = "R1";
  logic [15:0] lst_l = 0, lst_r = 0;
  logic lst_sp = 0, lst_err = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // behavioural reference model
  bit m_mid = 0, m_sp = 0, m_err = 0;
  int m_left = 0;
  bit e_vld = 0, e_sp = 0, e_err = 0;
  int e_l = 0, e_r = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mid = 0; e_vld = 0; e_l = 0; e_r = 0; e_sp = 0; e_err = 0;
    end else begin
      bit live, okf, src, v, c;
      int d, a, b;
      e_vld = 0;
      live = sp_lock && sp_orig && (sp_rate != 3);
      okf  = (req_rate == sp_rate) && !(req_mono && req_8b);
      if (m_mid && m_sp && !sp_lock) m_mid = 0;
      else begin
        src = m_mid ? m_sp : (live && okf);
        v = src ? sp_vld : adc_vld;
        c = src ? sp_ch : adc_ch;
        d = src ? int'($signed(sp_dat)) : int'($signed(adc_dat));
        if (v && !c) begin
          if (!m_mid) begin m_sp = src; m_err = live && !okf; end
          m_left = d; m_mid = 1;
        end else if (v && c && m_mid) begin
          m_mid = 0;
          if (req_mono) begin a = (m_left + d) >>> 1; b = 0; end
          else begin a = m_left; b = d; end
          if (req_8b) begin a = (a >>> 8) & 255; b = (b >>> 8) & 255; end
          else begin a = a & 16'hFFFF; b = b & 16'hFFFF; end
          e_vld = 1; e_l = a; e_r = b; e_sp = m_sp; e_err = m_err;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur, "rec_vld vs model", {31'd0, rec_vld}, {31'd0, e_vld});
      if (e_vld) begin
        chk(cur, "rec_l vs model", {16'd0, rec_l}, e_l);
        chk(cur, "rec_r vs model", {16'd0, rec_r}, e_r);
        chk(cur, "rec_from_sp vs model", {31'd0, rec_from_sp}, {31'd0, e_sp});
        chk(cur, "rec_err vs model", {31'd0, rec_err}, {31'd0, e_err});
      end
    end
    if (rec_vld) begin
      nfr++; lst_l = rec_l; lst_r = rec_r; lst_sp = rec_from_sp; lst_err = rec_err;
    end
  end

  task automatic put(input bit sv, input bit sc, input logic [15:0] sd,
                     input bit av, input bit ac, input logic [15:0] ad);
    @(negedge clk);
    sp_vld = sv; sp_ch = sc; sp_dat = sd;
    adc_vld = av; adc_ch = ac; adc_dat = ad;
  endtask

  task automatic idle2();
    put(0, 0, 0, 0, 0, 0);
    put(0, 0, 0, 0, 0, 0);
    #1;
  endtask

  task automatic frm(input logic [15:0] sl, sr, al, ar);
    put(1, 0, sl, 1, 0, al);
    put(1, 1, sr, 1, 1, ar);
    idle2();
  endtask

  task automatic expect_frame(input string tag, input int n0, input logic [15:0] l, r, input bit s, e);
    chk(tag, "frame count", nfr, n0 + 1);
    chk(tag, "left", {16'd0, lst_l}, {16'd0, l});
    chk(tag, "right", {16'd0, lst_r}, {16'd0, r});
    chk(tag, "from_sp", {31'd0, lst_sp}, {31'd0, s});
    chk(tag, "err", {31'd0, lst_err}, {31'd0, e});
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog: actual running expected finished");
    summary();
  end

  initial begin
    int n0;
    rst_n = 0;
    sp_vld = 0; sp_ch = 0; sp_dat = 0; sp_lock = 1; sp_orig = 1; sp_rate = 2;
    adc_vld = 0; adc_ch = 0; adc_dat = 0;
    req_mono = 0; req_8b = 0; req_rate = 2;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset rec_vld", {31'd0, rec_vld}, 0);
    chk("R1", "reset rec_l", {16'd0, rec_l}, 0);
    chk("R1", "reset flags", {30'd0, rec_from_sp, rec_err}, 0);
    @(negedge clk); rst_n = 1;
    idle2();
    chk("R1", "idle after reset", {15'd0, rec_vld, rec_l}, 0);

    cur = "R2"; n0 = nfr;
    frm(16'd1000, 16'hF830, 16'd5, 16'd6);
    expect_frame("R2", n0, 16'd1000, 16'hF830, 1, 0);
    chk("R9", "outputs hold", {16'd0, rec_l}, 16'd1000);

    cur = "R3"; sp_lock = 0; n0 = nfr;
    frm(16'h1111, 16'h1112, 16'h0111, 16'h0222);
    expect_frame("R3", n0, 16'h0111, 16'h0222, 0, 0);

    cur = "R4"; sp_lock = 1; sp_orig = 0; n0 = nfr;
    frm(16'h1111, 16'h1112, 16'h0333, 16'h0444);
    expect_frame("R4", n0, 16'h0333, 16'h0444, 0, 0);

    cur = "R5"; sp_orig = 1; sp_rate = 3; n0 = nfr;
    frm(16'h1111, 16'h1112, 16'h0555, 16'h0666);
    expect_frame("R5", n0, 16'h0555, 16'h0666, 0, 0);

    cur = "R6"; sp_rate = 2; req_rate = 1; n0 = nfr;
    frm(16'h1111, 16'h1112, 16'h0777, 16'h0888);
    expect_frame("R6", n0, 16'h0777, 16'h0888, 0, 1);
    req_rate = 2;

    cur = "R7"; req_mono = 1; n0 = nfr;
    frm(16'd1001, 16'hF830, 16'd7, 16'd9);
    expect_frame("R7", n0, 16'hFE0C, 16'h0000, 1, 0);
    req_mono = 0;

    cur = "R8"; req_8b = 1; n0 = nfr;
    frm(16'h1234, 16'hABCD, 16'd7, 16'd9);
    expect_frame("R8", n0, 16'h0012, 16'h00AB, 1, 0);

    cur = "R6"; req_mono = 1; n0 = nfr;
    frm(16'h1234, 16'hABCD, 16'h0400, 16'h0200);
    expect_frame("R6", n0, 16'h0003, 16'h0000, 0, 1);
    req_mono = 0; req_8b = 0;

    cur = "R10"; n0 = nfr;
    put(1, 0, 16'h1111, 1, 0, 16'h2222);
    put(1, 1, 16'h3333, 1, 1, 16'h4444); sp_orig = 0;
    idle2();
    expect_frame("R10", n0, 16'h1111, 16'h3333, 1, 0);
    n0 = nfr;
    frm(16'h1111, 16'h1112, 16'h0999, 16'h0AAA);
    expect_frame("R10", n0, 16'h0999, 16'h0AAA, 0, 0);
    sp_orig = 1; sp_lock = 0; n0 = nfr;
    put(1, 0, 16'h6666, 1, 0, 16'h5555);
    put(1, 1, 16'h8888, 1, 1, 16'h7777); sp_lock = 1;
    idle2();
    expect_frame("R10", n0, 16'h5555, 16'h7777, 0, 0);

    cur = "R11"; n0 = nfr;
    put(1, 0, 16'h0A0A, 1, 0, 16'h0B0B);
    put(1, 1, 16'h0C0C, 1, 1, 16'h0D0D); sp_lock = 0;
    idle2();
    chk("R11", "partial frame dropped", nfr, n0);
    frm(16'h1111, 16'h1112, 16'h0E0E, 16'h0F0F);
    expect_frame("R11", n0, 16'h0E0E, 16'h0F0F, 0, 0);
    sp_lock = 1;

    cur = "R9"; n0 = nfr;
    put(1, 1, 16'h1234, 1, 1, 16'h4321);
    idle2();
    chk("R9", "stray right ignored", nfr, n0);
    put(1, 0, 16'h0101, 0, 0, 0);
    put(1, 0, 16'h0202, 0, 0, 0);
    put(1, 1, 16'h0303, 0, 0, 0);
    idle2();
    expect_frame("R9", n0, 16'h0202, 16'h0303, 1, 0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule